// File: doc/BRIEF.md
# Serial Frame Transmitter with Capture Acknowledge

This block turns 8-bit words into asynchronous serial frames on one output line. A producer places a word on `word_in` and raises `word_valid`. The block captures the word and pulses `word_taken` for one clock. It then drives a low start bit, the eight data bits with the least significant bit first, and a high stop bit. Each bit lasts sixteen clocks for every unit of `divisor`. The divisor is sampled when the word is captured.

A producer that keeps `word_valid` high with the next word during a frame gets that word captured in the last clock of the current stop bit. The acknowledge pulses in that clock and the next start bit begins on the following clock, so consecutive frames leave no idle gap. With no word pending, the line rests high after a full stop bit.

The controller is a five-state machine. IDLE holds the line high and moves to LOAD when `word_valid` is seen. LOAD is the single capture clock: the acknowledge is high, the line is high, and the state always moves to START. START drives low for one bit period and moves to DATA. DATA sends eight bit periods and moves to STOP after the eighth. STOP drives high. It moves to LOAD when `word_valid` is seen in its next-to-last clock, and otherwise moves to IDLE when its period ends.

Top module: `serial_frame_tx`

## Requirements
- R1: A frame is a low start bit, then word bits 0 through 7 in that order, then a high stop bit.
- R2: Every bit lasts 16 × `divisor` clocks, and a `divisor` of 0 is treated as 1. The divisor in effect is the value present at capture, and later changes to `divisor` do not alter the frame in progress.
- R3: `line_out` is high while idle and in every clock where reset is asserted.
- R4: When `word_valid` is high at a clock edge while idle, `word_taken` is high for the next clock with the line still high. A full-length start bit follows.
- R5: When `word_valid` is high at the edge that ends the next-to-last clock of a stop bit, `word_taken` is high during the last stop clock with the line high. The next start bit begins on the following clock, so stop plus start spans exactly two bit periods.
- R6: `word_taken` is high only in a capture clock and never for two clocks in a row. It is low during every start, data and stop bit clock.
- R7: The word is copied at the capture edge. Later changes to `word_in` do not change the frame in progress.
- R8: With no pending word at the end of a stop bit, the line stays high and idle.
- R9: A synchronous reset returns the block to idle at the next edge, with the line high and `word_taken` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| divisor | input | 8 | Bit period in units of 16 clocks, sampled at capture |
| word_in | input | 8 | Word to transmit |
| word_valid | input | 1 | A word is offered on `word_in` |
| line_out | output | 1 | Serial line, high when idle |
| word_taken | output | 1 | One-clock pulse in the capture clock |

## Verification
The assertions check on every clock that the acknowledge is a single-clock pulse with the line high, that a start bit always follows it, and that the line is high in the idle and stop states. Bit ordering, the length of each bit under different divisors, and immunity to divisor and word changes after capture can only be shown by the bench's frames. The same holds for the gapless hand-off between frames, the return to idle, and the recovery from a reset mid-frame.

// File: rtl/sft_pkg.sv
package sft_pkg;
    localparam int WORD_W = 8;
    localparam int OVERSAMPLE = 16;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_START,
        S_DATA,
        S_STOP
    } sft_state_e;
endpackage

// File: rtl/sft_bit_timer.sv
module sft_bit_timer #(
    parameter int DIV_W = 8,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic             hold,
    input  logic [DIV_W-1:0] div,
    output logic             at_last,
    output logic             at_pre
);
    localparam int PER_W = DIV_W + $clog2(OVS);

    logic [PER_W-1:0] period;
    logic [PER_W-1:0] cnt;
    logic [DIV_W-1:0] div_eff;

    assign div_eff = (div == '0) ? DIV_W'(1) : div;

    // period is sampled only at the capture edge
    always_ff @(posedge clk) begin
        if (rst) begin
            period <= PER_W'(OVS);
        end else if (capture) begin
            period <= PER_W'(div_eff) * PER_W'(OVS);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || hold || at_last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + PER_W'(1);
        end
    end

    assign at_last = (cnt == period - PER_W'(1));
    assign at_pre  = (cnt == period - PER_W'(2));
endmodule

// File: rtl/sft_shifter.sv
module sft_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         advance,
    input  logic [W-1:0] din,
    output logic         lsb
);
    logic [W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= din;
        end else if (advance) begin
            sreg <= {1'b0, sreg[W-1:1]};
        end
    end

    assign lsb = sreg[0];
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import sft_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_valid,
    output logic              line_out,
    output logic              word_taken
);
    localparam int IDX_W = $clog2(WORD_W);

    sft_state_e state, state_nx;
    logic [IDX_W-1:0] bit_idx;
    logic at_last, at_pre, capture, hold, advance, data_bit, last_data;

    assign capture   = word_valid &&
                       ((state == S_IDLE) || (state == S_STOP && at_pre));
    assign hold      = (state == S_IDLE) || (state == S_LOAD);
    assign advance   = (state == S_DATA) && at_last;
    assign last_data = (bit_idx == IDX_W'(WORD_W - 1));

    sft_bit_timer #(.DIV_W(DIV_W), .OVS(OVERSAMPLE)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .hold    (hold),
        .div     (divisor),
        .at_last (at_last),
        .at_pre  (at_pre)
    );

    sft_shifter #(.W(WORD_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (capture),
        .advance (advance),
        .din     (word_in),
        .lsb     (data_bit)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // data bit index
    always_ff @(posedge clk) begin
        if (rst || state == S_LOAD) begin
            bit_idx <= '0;
        end else if (advance) begin
            bit_idx <= bit_idx + IDX_W'(1);
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (word_valid) state_nx = S_LOAD;
            S_LOAD:  state_nx = S_START;
            S_START: if (at_last) state_nx = S_DATA;
            S_DATA:  if (at_last && last_data) state_nx = S_STOP;
            S_STOP: begin
                if (at_pre && word_valid) state_nx = S_LOAD;
                else if (at_last)         state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        line_out   = 1'b1;
        word_taken = 1'b0;
        unique case (state)
            S_IDLE:  line_out = 1'b1;
            S_LOAD:  word_taken = 1'b1;
            S_START: line_out = 1'b0;
            S_DATA:  line_out = data_bit;
            S_STOP:  line_out = 1'b1;
            default: line_out = 1'b1;
        endcase
    end
endmodule

// File: rtl/sft_checker.sv
module sft_checker
    import sft_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       line,
    input logic       ack,
    input sft_state_e st
);
    p_ack_single_r6: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    p_ack_line_high_r5: assert property (@(posedge clk) disable iff (rst)
        ack |-> line);

    p_start_after_ack_r4: assert property (@(posedge clk) disable iff (rst)
        ack |=> !line);

    p_idle_high_r3: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE) |-> line);

    p_stop_high_r1: assert property (@(posedge clk) disable iff (rst)
        (st == S_STOP) |-> (line && !ack));
endmodule

bind serial_frame_tx sft_checker u_chk (
    .clk  (clk),
    .rst  (rst),
    .line (line_out),
    .ack  (word_taken),
    .st   (state)
);

// File: tb/tb_serial_frame_tx.sv
module tb_serial_frame_tx;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] divisor;
    logic [7:0] word_in;
    logic       word_valid;
    logic       line_out;
    logic       word_taken;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_frame_tx dut (
        .clk        (clk),
        .rst        (rst),
        .divisor    (divisor),
        .word_in    (word_in),
        .word_valid (word_valid),
        .line_out   (line_out),
        .word_taken (word_taken)
    );

    function automatic int bit_len(input logic [7:0] d);
        return (d == 8'd0) ? 16 : int'(d) * 16;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // n clocks of constant line level with acknowledge low
    task automatic seg(input logic lvl, input int n, input string req, input string what);
        bit ok = 1'b1;
        logic [1:0] bad = {lvl, 1'b0};
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (ok && (line_out !== lvl || word_taken !== 1'b0)) begin
                ok = 1'b0;
                bad = {line_out, word_taken};
            end
        end
        chk(ok, req, what, {30'd0, bad}, {30'd0, lvl, 1'b0});
    endtask

    task automatic idle_gap(input int n);
        seg(1'b1, n, "R8", "idle line high");
    endtask

    // offer a word while idle; returns at the negedge of the capture clock
    task automatic launch(input logic [7:0] w, input logic [7:0] d);
        divisor = d; word_in = w; word_valid = 1'b1;
        @(negedge clk);
        chk(word_taken === 1'b1 && line_out === 1'b1, "R4", "idle capture",
            {30'd0, word_taken, line_out}, 32'h3);
    endtask

    // at the capture clock's negedge; runs one frame
    task automatic frame(input logic [7:0] w, input int per, input bit more,
                         input logic [7:0] nxt, output int nxt_per);
        logic [7:0] nd = 8'($urandom_range(3, 0));
        divisor = nd;  // R2: change after capture must not matter
        if (more) begin
            word_in = nxt; word_valid = 1'b1;
        end else begin
            word_in = 8'($urandom); word_valid = 1'b0;  // R7
        end
        nxt_per = bit_len(nd);
        seg(1'b0, per, "R1", "start bit");
        for (int b = 0; b < 8; b++) seg(w[b], per, "R1", $sformatf("data bit %0d", b));
        seg(1'b1, per - 1, "R2", "stop bit");
        @(negedge clk);
        chk(line_out === 1'b1 && word_taken === more, more ? "R5" : "R8",
            "last stop clock", {30'd0, line_out, word_taken}, {30'd0, 1'b1, more});
    endtask

    initial begin
        int p, np;
        logic [7:0] w, nw, d;
        bit more;
        void'($urandom(32'd2024));
        rst = 1'b1; divisor = 8'd2; word_in = 8'h00; word_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(line_out === 1'b1 && word_taken === 1'b0, "R3", "line in reset",
            {30'd0, line_out, word_taken}, 32'h2);
        rst = 1'b0;
        idle_gap(5);

        // directed single frame, divisor 2
        launch(8'h4b, 8'd2);
        frame(8'h4b, 32, 1'b0, 8'h00, np);
        idle_gap(4);

        // directed chain of two frames
        launch(8'hb4, 8'd2);
        frame(8'hb4, 32, 1'b1, 8'haa, np);
        frame(8'haa, np, 1'b0, 8'h00, np);
        idle_gap(2);

        // divisor zero treated as one
        launch(8'h81, 8'd0);
        frame(8'h81, 16, 1'b0, 8'h00, np);
        idle_gap(1);

        // random frames, some chained
        w = 8'($urandom); d = 8'($urandom_range(3, 0));
        launch(w, d);
        p = bit_len(d);
        for (int k = 0; k < 20; k++) begin
            more = (k < 19) ? bit'($urandom_range(1, 0)) : 1'b0;
            nw = 8'($urandom);
            frame(w, p, more, nw, np);
            if (more) begin
                w = nw; p = np;
            end else if (k < 19) begin
                idle_gap(int'($urandom_range(4, 1)));
                w = 8'($urandom); d = 8'($urandom_range(3, 0));
                launch(w, d);
                p = bit_len(d);
            end
        end
        idle_gap(3);

        // reset in the middle of a frame
        launch(8'h5a, 8'd1);
        word_valid = 1'b0;
        repeat (40) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(line_out === 1'b1 && word_taken === 1'b0, "R9", "mid-frame reset",
            {30'd0, line_out, word_taken}, 32'h2);
        @(negedge clk);
        rst = 1'b0;
        idle_gap(3);
        launch(8'hc3, 8'd1);
        frame(8'hc3, 16, 1'b0, 8'h00, np);
        idle_gap(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule